// File: doc/BRIEF.md
# Claimable Inter-Core Mailbox Slot

This block is one message slot shared by several cores over a simple synchronous register bus with address, write strobe, write data and combinational read data. A core takes the slot by writing its one-hot channel code into the owner register and reading it back. If the read-back matches, the claim succeeded. Any later non-zero write to the owner register is dropped until the owner releases the slot by writing zero. A release also wipes every other register in the slot.

While the slot is owned, the owner fills in the data words and picks the receiving channels through separate set and clear locations, so no read-modify-write is needed. It enables interrupt lines the same way. It then raises the "message" bit of the send register. Each channel gets one raw and one masked interrupt line. The receivers can withdraw their bits one by one. With automatic acknowledge enabled, the slot turns the message into an acknowledge on its own once the last receiver has withdrawn. With chaining enabled, the acknowledge goes out as a one-cycle pulse to the next slot instead of interrupting the owner. An incoming pulse from the previous slot starts this slot's message.

Top module: `ipc_mailbox_slot`

## Requirements
- R1: The owner register (address 0x00) takes a write only while it reads zero. While it is non-zero, every non-zero write to it is ignored, and reading it back returns the first claimant's code.
- R2: Writing zero to 0x00 clears the owner, receiver, enable, send and mode registers and every data word in the next cycle.
- R3: While the owner register is zero, writes to any other address leave all registers unchanged and reading zero.
- R4: A write to 0x04 ORs the written bits into the receiver register, and a write to 0x08 clears them. The receiver register reads at 0x0C. The enable register works the same way, with set at 0x10, clear at 0x14 and read at 0x18.
- R5: For channel c, the raw interrupt is (receiver[c] AND send[0]) OR (owner[c] AND send[1] AND NOT mode[1]). The masked interrupt is the raw interrupt AND enable[c].
- R6: The send register (0x1C, bit 0 = message, bit 1 = acknowledge) never holds 2'b11. A write of 2'b11 is dropped and the old value is kept.
- R7: When mode bit 0 (auto-acknowledge, mode at 0x20) is set, send reads 2'b01 and the receiver register is zero, send becomes 2'b10 at the next clock edge.
- R8: When mode bit 1 (chaining) is set, link_out is high for exactly one cycle after send bit 1 becomes set, and the owner's acknowledge interrupt stays low.
- R9: A high link_in while the slot is owned sets send to 2'b01 at the next edge. A high link_in has no effect on an unowned slot. A bus write to send wins over link_in.
- R10: Data word i (32 bits) is at 0x24 + 4*i for i below NUM_DATA. Addresses for words that are not implemented read zero and ignore writes.
- R11: After reset every register reads zero, and all interrupt lines and link_out are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| link_in | input | 1 | Start pulse from the previous slot |
| link_out | output | 1 | Start pulse to the next slot |
| irq_raw | output | NUM_CH | Raw interrupt per channel |
| irq_masked | output | NUM_CH | Raw interrupt gated by the enable register |

## Verification
The claim logic is exercised by racing claims, by a claim with a different code, and by releases. These runs separate a slot that locks from one that lets a later writer take over. The send and interrupt path runs with messages to several receivers, then with a forbidden 2'b11 write. The receivers are withdrawn one at a time, so an acknowledge fired by a partial clear is told apart from the correct one after the last clear. A long random mix of addresses, one-hot and random data, releases and link pulses follows. It is compared cycle by cycle against a bench model, which finds ordering faults between release, bus writes, link pulses and the automatic acknowledge.

// File: rtl/mbox_pkg.sv
// Shared constants for the mailbox slot: the register address map and mode bits.
// Assumes byte addressing with 32-bit registers on 4-byte steps.
package mbox_pkg;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned WORD_W = 32;

    localparam logic [ADDR_W-1:0] A_OWNER = 8'h00;
    localparam logic [ADDR_W-1:0] A_RSET  = 8'h04;
    localparam logic [ADDR_W-1:0] A_RCLR  = 8'h08;
    localparam logic [ADDR_W-1:0] A_RRD   = 8'h0C;
    localparam logic [ADDR_W-1:0] A_ESET  = 8'h10;
    localparam logic [ADDR_W-1:0] A_ECLR  = 8'h14;
    localparam logic [ADDR_W-1:0] A_ERD   = 8'h18;
    localparam logic [ADDR_W-1:0] A_SEND  = 8'h1C;
    localparam logic [ADDR_W-1:0] A_MODE  = 8'h20;
    localparam logic [ADDR_W-1:0] A_DATA0 = 8'h24;

    localparam int unsigned MODE_AUTOACK = 0;
    localparam int unsigned MODE_CHAIN   = 1;

    localparam logic [1:0] SEND_IDLE = 2'b00;
    localparam logic [1:0] SEND_MSG  = 2'b01;
    localparam logic [1:0] SEND_ACK  = 2'b10;
    localparam logic [1:0] SEND_BAD  = 2'b11;
endpackage

// File: rtl/mbox_owner_reg.sv
// Owner register of the slot. It accepts a code only while empty and is emptied
// only by an all-zero write, which is also reported as the slot-wide release.
// Assumes wr_owner is already decoded from the bus address.
module mbox_owner_reg #(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_owner,
    input  logic [31:0]       wdata,
    output logic [NUM_CH-1:0] owner_q,
    output logic              release_o
);
    // Release is any all-zero write to the owner location.
    assign release_o = wr_owner && (wdata == 32'd0);

    // Claim when empty, clear on release, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= '0;
        end else if (release_o) begin
            owner_q <= '0;
        end else if (wr_owner && (owner_q == '0)) begin
            owner_q <= wdata[NUM_CH-1:0];
        end
    end
endmodule

// File: rtl/mbox_setclr_reg.sv
// Bit register modified only through separate set and clear strobes.
// Assumes the strobes are already gated by ownership; clr_all has top priority.
module mbox_setclr_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] bits,
    output logic [W-1:0] q
);
    // OR in on set, mask out on clear, wipe on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr_all) begin
            q <= '0;
        end else if (set_en) begin
            q <= q | bits;
        end else if (clr_en) begin
            q <= q & ~bits;
        end
    end
endmodule

// File: rtl/mbox_send_ctrl.sv
// Send and mode registers with the automatic acknowledge and chain pulses.
// Priority: release, then bus write, then incoming link, then auto-acknowledge.
// Assumes wr_send and wr_mode are already gated by ownership.
module mbox_send_ctrl
    import mbox_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_all,
    input  logic       owned,
    input  logic       wr_send,
    input  logic       wr_mode,
    input  logic [1:0] wbits,
    input  logic       rcv_empty,
    input  logic       link_in,
    output logic [1:0] send_q,
    output logic [1:0] mode_q,
    output logic       link_out
);
    logic [1:0] send_nx;
    logic       ack_prev_q;

    // Next value of the send register by priority.
    always_comb begin
        send_nx = send_q;
        if (clr_all) begin
            send_nx = SEND_IDLE;
        end else if (wr_send) begin
            if (wbits != SEND_BAD) send_nx = wbits;
        end else if (link_in && owned) begin
            send_nx = SEND_MSG;
        end else if (mode_q[MODE_AUTOACK] && (send_q == SEND_MSG) && rcv_empty) begin
            send_nx = SEND_ACK;
        end
    end

    // Send register state.
    always_ff @(posedge clk) begin
        if (!rst_n) send_q <= SEND_IDLE;
        else        send_q <= send_nx;
    end

    // Mode register state.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= 2'b00;
        else if (clr_all) mode_q <= 2'b00;
        else if (wr_mode) mode_q <= wbits;
    end

    // Delayed acknowledge bit for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_prev_q <= 1'b0;
        else        ack_prev_q <= send_q[1];
    end

    assign link_out = mode_q[MODE_CHAIN] && send_q[1] && !ack_prev_q;
endmodule

// File: rtl/ipc_mailbox_slot.sv
// One claimable inter-core mailbox slot on a synchronous register bus.
// Decodes the bus, holds the data words and forms per-channel interrupts.
// Assumes NUM_CH in 1..32 and NUM_DATA in 0..7; reads are combinational.
module ipc_mailbox_slot
    import mbox_pkg::*;
#(
    parameter int unsigned NUM_CH   = 8,
    parameter int unsigned NUM_DATA = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              link_in,
    output logic              link_out,
    output logic [NUM_CH-1:0] irq_raw,
    output logic [NUM_CH-1:0] irq_masked
);
    localparam int unsigned DATA_SLOTS = (NUM_DATA == 0) ? 1 : NUM_DATA;

    logic [NUM_CH-1:0] owner_q;
    logic [NUM_CH-1:0] rcv_q;
    logic [NUM_CH-1:0] en_q;
    logic [1:0]        send_q;
    logic [1:0]        mode_q;
    logic              release_w;
    logic              owned;
    logic              wr_owned;
    logic [31:0]       data_q [DATA_SLOTS];

    assign owned    = (owner_q != '0);
    assign wr_owned = bus_we && owned;

    mbox_owner_reg #(.NUM_CH(NUM_CH)) u_owner (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_owner  (bus_we && (bus_addr == A_OWNER)),
        .wdata     (bus_wdata),
        .owner_q   (owner_q),
        .release_o (release_w)
    );

    mbox_setclr_reg #(.W(NUM_CH)) u_rcv (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (release_w),
        .set_en  (wr_owned && (bus_addr == A_RSET)),
        .clr_en  (wr_owned && (bus_addr == A_RCLR)),
        .bits    (bus_wdata[NUM_CH-1:0]),
        .q       (rcv_q)
    );

    mbox_setclr_reg #(.W(NUM_CH)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (release_w),
        .set_en  (wr_owned && (bus_addr == A_ESET)),
        .clr_en  (wr_owned && (bus_addr == A_ECLR)),
        .bits    (bus_wdata[NUM_CH-1:0]),
        .q       (en_q)
    );

    mbox_send_ctrl u_send (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (release_w),
        .owned     (owned),
        .wr_send   (wr_owned && (bus_addr == A_SEND)),
        .wr_mode   (wr_owned && (bus_addr == A_MODE)),
        .wbits     (bus_wdata[1:0]),
        .rcv_empty (rcv_q == '0),
        .link_in   (link_in),
        .send_q    (send_q),
        .mode_q    (mode_q),
        .link_out  (link_out)
    );

    // Data words: one register per implemented word, or a zero tie-off.
    generate
        if (NUM_DATA == 0) begin : g_nodata
            assign data_q[0] = 32'd0;
        end else begin : g_data
            for (genvar i = 0; i < NUM_DATA; i++) begin : g_word
                // Store one data word; wiped on release.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        data_q[i] <= 32'd0;
                    end else if (release_w) begin
                        data_q[i] <= 32'd0;
                    end else if (wr_owned && (bus_addr == A_DATA0 + 8'(4 * i))) begin
                        data_q[i] <= bus_wdata;
                    end
                end
            end
        end
    endgenerate

    // Read multiplexer; unknown and write-only addresses read zero.
    always_comb begin
        bus_rdata = 32'd0;
        case (bus_addr)
            A_OWNER: bus_rdata[NUM_CH-1:0] = owner_q;
            A_RRD:   bus_rdata[NUM_CH-1:0] = rcv_q;
            A_ERD:   bus_rdata[NUM_CH-1:0] = en_q;
            A_SEND:  bus_rdata[1:0]        = send_q;
            A_MODE:  bus_rdata[1:0]        = mode_q;
            default: begin
                for (int i = 0; i < NUM_DATA; i++) begin
                    if (bus_addr == A_DATA0 + 8'(4 * i)) bus_rdata = data_q[i];
                end
            end
        endcase
    end

    // Per-channel interrupts; the owner acknowledge is held back while chaining.
    assign irq_raw    = (rcv_q & {NUM_CH{send_q[0]}})
                      | (owner_q & {NUM_CH{send_q[1] & ~mode_q[MODE_CHAIN]}});
    assign irq_masked = irq_raw & en_q;
endmodule

// File: rtl/mbox_checker.sv
// Temporal checks on the mailbox slot, bound to every instance of the top.
// Assumes a synchronous active-low reset held for at least one clock.
module mbox_checker
    import mbox_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [7:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              link_in,
    input logic              link_out,
    input logic [NUM_CH-1:0] owner,
    input logic [NUM_CH-1:0] rcv,
    input logic [1:0]        send,
    input logic [1:0]        mode
);
    assert_claim_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(owner) != '0) && !($past(bus_we) && ($past(bus_addr) == A_OWNER)
                                  && ($past(bus_wdata) == 32'd0))
        |-> owner == $past(owner));

    assert_release_wipes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && (bus_addr == A_OWNER) && (bus_wdata == 32'd0))
        |-> (owner == '0) && (rcv == '0) && (send == 2'b00) && (mode == 2'b00));

    assert_unowned_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == '0) |-> (rcv == '0) && (send == 2'b00) && (mode == 2'b00));

    assert_no_bad_send_R6: assert property (@(posedge clk) disable iff (!rst_n)
        send != SEND_BAD);

    assert_auto_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode[MODE_AUTOACK] && (send == SEND_MSG) && (rcv == '0) && !link_in
              && !(bus_we && ((bus_addr == A_OWNER) || (bus_addr == A_SEND))))
        |-> send == SEND_ACK);

    assert_link_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        link_out |-> mode[MODE_CHAIN] && send[1]);

    assert_link_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        link_out |=> !link_out);

    assert_link_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(link_in && (owner != '0) && !bus_we) |-> send == SEND_MSG);
endmodule

bind ipc_mailbox_slot mbox_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .link_in   (link_in),
    .link_out  (link_out),
    .owner     (owner_q),
    .rcv       (rcv_q),
    .send      (send_q),
    .mode      (mode_q)
);

// File: tb/tb_ipc_mailbox_slot.sv
// Bench for the mailbox slot: directed corners, then seeded random traffic,
// all compared against a cycle model written from the requirements.
module tb_ipc_mailbox_slot;
    localparam int unsigned NCH = 8;
    localparam int unsigned NDW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      addr = 8'h00;
    logic            we = 1'b0;
    logic [31:0]     wdata = 32'h0;
    logic            link_in = 1'b0;
    logic [31:0]     rdata;
    logic            link_out;
    logic [NCH-1:0]  irq_raw;
    logic [NCH-1:0]  irq_masked;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    logic [31:0] last_rd;
    int unsigned link_seen = 0;

    // Model state
    logic [NCH-1:0] m_own = '0, m_rcv = '0, m_en = '0;
    logic [1:0]     m_snd = '0, m_mode = '0;
    logic           m_ackp = 1'b0;
    logic [31:0]    m_dat [NDW];
    logic [NCH-1:0] n_own, n_rcv, n_en;
    logic [1:0]     n_snd, n_mode;
    logic           n_ackp;
    logic [31:0]    n_dat [NDW];

    always #4 clk = ~clk;

    ipc_mailbox_slot #(.NUM_CH(NCH), .NUM_DATA(NDW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .link_in(link_in), .link_out(link_out),
        .irq_raw(irq_raw), .irq_masked(irq_masked)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] r = 32'd0;
        case (a)
            8'h00: r[NCH-1:0] = m_own;
            8'h0C: r[NCH-1:0] = m_rcv;
            8'h18: r[NCH-1:0] = m_en;
            8'h1C: r[1:0] = m_snd;
            8'h20: r[1:0] = m_mode;
            default: for (int i = 0; i < NDW; i++) if (a == 8'h24 + 8'(4*i)) r = m_dat[i];
        endcase
        return r;
    endfunction

    function automatic logic [NCH-1:0] m_raw();
        return (m_rcv & {NCH{m_snd[0]}}) | (m_own & {NCH{m_snd[1] & ~m_mode[1]}});
    endfunction

    // Requirement-driven next state of the model.
    task automatic m_next(input logic w, input logic [7:0] a, input logic [31:0] d, input logic l);
        logic owned = (m_own != '0);
        n_own = m_own; n_rcv = m_rcv; n_en = m_en; n_snd = m_snd; n_mode = m_mode;
        n_ackp = m_snd[1];
        for (int i = 0; i < NDW; i++) n_dat[i] = m_dat[i];
        if (w && a == 8'h00 && d == 32'd0) begin
            n_own = '0; n_rcv = '0; n_en = '0; n_snd = '0; n_mode = '0;
            for (int i = 0; i < NDW; i++) n_dat[i] = 32'd0;
        end else begin
            if (w && a == 8'h00 && !owned) n_own = d[NCH-1:0];
            if (w && owned) begin
                case (a)
                    8'h04: n_rcv = m_rcv | d[NCH-1:0];
                    8'h08: n_rcv = m_rcv & ~d[NCH-1:0];
                    8'h10: n_en = m_en | d[NCH-1:0];
                    8'h14: n_en = m_en & ~d[NCH-1:0];
                    8'h20: n_mode = d[1:0];
                    default: for (int i = 0; i < NDW; i++) if (a == 8'h24 + 8'(4*i)) n_dat[i] = d;
                endcase
            end
            if (w && owned && a == 8'h1C) begin
                if (d[1:0] != 2'b11) n_snd = d[1:0];
            end else if (l && owned) n_snd = 2'b01;
            else if (m_mode[0] && m_snd == 2'b01 && m_rcv == '0) n_snd = 2'b10;
        end
    endtask

    // One bus cycle: drive, check read data, clock, update model, check outputs.
    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d, input logic l);
        @(negedge clk);
        we = w; addr = a; wdata = d; link_in = l;
        #1;
        last_rd = rdata;
        if (!w) chk("R1/R4/R10 readback", rdata, m_read(a));
        m_next(w, a, d, l);
        @(posedge clk); #1;
        m_own = n_own; m_rcv = n_rcv; m_en = n_en; m_snd = n_snd; m_mode = n_mode; m_ackp = n_ackp;
        for (int i = 0; i < NDW; i++) m_dat[i] = n_dat[i];
        chk("R5 raw", 32'(irq_raw), 32'(m_raw()));
        chk("R5 masked", 32'(irq_masked), 32'(m_raw() & m_en));
        chk("R8 link_out", 32'(link_out), 32'(m_mode[1] & m_snd[1] & ~m_ackp));
        if (link_out) link_seen++;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d); step(1'b1, a, d, 1'b0); endtask
    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        step(1'b0, a, 32'd0, 1'b0);
        chk(tag, last_rd, exp);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int unsigned base;
        for (int i = 0; i < NDW; i++) m_dat[i] = 32'd0;
        void'($urandom(32'h1234_5678));
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11: reset state
        chk("R11 irq_raw", 32'(irq_raw), 32'd0);
        chk("R11 link_out", 32'(link_out), 32'd0);
        for (int k = 0; k <= 16; k++) rd(8'(4*k), 32'd0, "R11 reset read");

        // R1: claim and lock
        wr(8'h00, 32'h04);
        rd(8'h00, 32'h04, "R1 claim");
        wr(8'h00, 32'h08);
        rd(8'h00, 32'h04, "R1 second claim ignored");

        // R4: set/clear
        wr(8'h04, 32'h03); wr(8'h04, 32'h20); rd(8'h0C, 32'h23, "R4 rcv set");
        wr(8'h08, 32'h01); rd(8'h0C, 32'h22, "R4 rcv clear");
        wr(8'h10, 32'h26); wr(8'h14, 32'h04); rd(8'h18, 32'h22, "R4 enable");

        // R5 / R6: message, bad write, acknowledge
        wr(8'h1C, 32'h1);
        chk("R5 msg raw", 32'(irq_raw), 32'h22);
        chk("R5 msg masked", 32'(irq_masked), 32'h22);
        wr(8'h1C, 32'h3); rd(8'h1C, 32'h1, "R6 11 ignored");
        wr(8'h1C, 32'h2);
        chk("R5 ack raw", 32'(irq_raw), 32'h04);
        chk("R5 ack masked", 32'(irq_masked), 32'h00);

        // R10: data words
        wr(8'h24, 32'hDEAD_BEEF); rd(8'h24, 32'hDEAD_BEEF, "R10 word0");
        wr(8'h30, 32'h1357_9BDF); rd(8'h30, 32'h1357_9BDF, "R10 last word");
        wr(8'h34, 32'hFFFF_FFFF); rd(8'h34, 32'h0, "R10 unimplemented");

        // R2: release wipes
        wr(8'h00, 32'h0);
        rd(8'h00, 32'h0, "R2 owner"); rd(8'h0C, 32'h0, "R2 rcv"); rd(8'h18, 32'h0, "R2 en");
        rd(8'h1C, 32'h0, "R2 send"); rd(8'h24, 32'h0, "R2 data");

        // R3: unowned writes ignored
        wr(8'h04, 32'hFF); wr(8'h1C, 32'h1); wr(8'h20, 32'h3); wr(8'h28, 32'hABCD);
        rd(8'h0C, 32'h0, "R3 rcv"); rd(8'h1C, 32'h0, "R3 send");
        rd(8'h20, 32'h0, "R3 mode"); rd(8'h28, 32'h0, "R3 data");

        // R7: auto-acknowledge after the last receiver clears
        wr(8'h00, 32'h01); wr(8'h20, 32'h1); wr(8'h04, 32'h06); wr(8'h1C, 32'h1);
        wr(8'h08, 32'h02);
        step(1'b0, 8'h00, 32'd0, 1'b0);
        rd(8'h1C, 32'h1, "R7 partial clear keeps message");
        wr(8'h08, 32'h04);
        step(1'b0, 8'h00, 32'd0, 1'b0);
        rd(8'h1C, 32'h2, "R7 auto ack");
        chk("R7 ack irq", 32'(irq_raw), 32'h01);

        // R8: chained acknowledge
        wr(8'h1C, 32'h0); wr(8'h20, 32'h3); wr(8'h04, 32'h02); wr(8'h1C, 32'h1);
        base = link_seen;
        wr(8'h08, 32'h02);
        repeat (4) step(1'b0, 8'h1C, 32'd0, 1'b0);
        chk("R8 one pulse", link_seen - base, 32'd1);
        chk("R8 ack suppressed", 32'(irq_raw), 32'h0);

        // R9: incoming link
        wr(8'h1C, 32'h0);
        step(1'b0, 8'h00, 32'd0, 1'b1);
        rd(8'h1C, 32'h1, "R9 link starts message");
        wr(8'h00, 32'h0);
        step(1'b0, 8'h00, 32'd0, 1'b1);
        rd(8'h1C, 32'h0, "R9 unowned link ignored");

        // Random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] d;
            int unsigned sel = $urandom_range(0, 3);
            case (sel)
                0: d = 32'd0;
                1: d = 32'd1 << $urandom_range(0, NCH-1);
                2: d = $urandom;
                default: d = $urandom & 32'h3;
            endcase
            step(1'($urandom_range(0, 1)), 8'(4 * $urandom_range(0, 16)), d,
                 ($urandom_range(0, 15) == 0));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule